// File: doc/BRIEF.md
# Dual-Mode Serial Port (Asynchronous / Clocked Synchronous)

This block is one serial channel that a host sets up through a four-register bus. It can run in one of two modes. In asynchronous mode it sends and receives framed characters on a transmit line and a receive line, with no handshake pins. Each character has a start bit, eight data bits sent LSB first, an optional even or odd parity bit, and one or two stop bits. In clocked synchronous mode the block acts as clock master. It drives a serial clock pin and exchanges eight bits full-duplex for every byte written: its transmit line carries the outgoing bits, and its receive line is sampled for the incoming bits.

An internal rate generator makes a sampling tick every BAUD+1 system clocks. One bit lasts 16 ticks in both modes. The asynchronous receiver waits for a falling edge. It confirms the start bit near mid-bit, then decides each bit by a majority of three consecutive tick samples taken around the bit centre. Received characters go into a single holding register with a full flag. Framing, parity and overrun errors are kept as sticky flags. In synchronous mode overrun is the only error.

Register map (two-bit address): 0 = DATA (a write starts a transmission; a read returns the received byte and clears the full flag), 1 = CTRL (bit 0 synchronous mode, bit 1 two stop bits, bit 2 parity enable, bit 3 odd parity), 2 = STATUS (bit 0 transmitter busy, bit 1 receive full, bit 2 framing error, bit 3 parity error, bit 4 overrun; any write clears bits 2 to 4), 3 = BAUD divisor.

Top module: `sio_top`

## Requirements
- R1: After reset, txd and sclk are high, and STATUS, CTRL and BAUD all read 0.
- R2: A bit lasts 16*(BAUD+1) system clocks in both modes.
- R3: In asynchronous mode, a write to DATA while the transmitter is idle sends a low start bit, then the eight data bits LSB first, then one stop bit (CTRL bit 1 = 0) or two stop bits (CTRL bit 1 = 1). STATUS bit 0 stays set until the last stop bit has ended.
- R4: With CTRL bit 2 set, a parity bit follows the data. It makes the number of ones even when CTRL bit 3 = 0, and odd when CTRL bit 3 = 1.
- R5: A write to DATA while STATUS bit 0 is set is ignored, and the character already being sent goes out unchanged.
- R6: The asynchronous receiver decides each bit by a majority of three samples around the bit centre, so a one-sample glitch does not corrupt the data. A low pulse shorter than half a bit does not produce a character.
- R7: A received character whose first stop bit samples low sets STATUS bit 2.
- R8: With parity enabled, a received character with the wrong parity sets STATUS bit 3. A correct one does not.
- R9: A character that completes while STATUS bit 1 is set sets STATUS bit 4, and DATA keeps the earlier character.
- R10: Reading DATA clears STATUS bit 1. Writing STATUS clears bits 2 to 4.
- R11: In synchronous mode (CTRL bit 0 = 1), sclk is low for the first half of each bit and high for the second half, and it idles high. The eight bits of the written byte appear on txd LSB first and change only as sclk falls. rxd is sampled as sclk rises, and the eight sampled bits become the received byte, first bit as LSB.
- R12: In synchronous mode, overrun (STATUS bit 4) is the only error flag that can be set.
- R13: In asynchronous mode, sclk stays high, and txd is high whenever the transmitter is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (read side effects) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| rxd | input | 1 | Receive line (asynchronous data or synchronous data in) |
| txd | output | 1 | Transmit line |
| sclk | output | 1 | Serial clock in synchronous mode, high otherwise |

## Verification
The assertions assume that CTRL is not rewritten while a transmission is in progress, because the idle-line and clock-hold properties compare the live mode bit with a transfer that latched the mode when it started. They also assume that the bus never asserts read and write in the same cycle. The stimulus changes CTRL only between transfers, after STATUS bit 0 has cleared, and its register tasks strobe one operation at a time. Receive frames are driven at the exact bit length of the programmed divisor, and any glitch is shorter than the spacing between samples.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam logic [1:0] A_DATA = 2'd0;
  localparam logic [1:0] A_CTRL = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;
  localparam logic [1:0] A_BAUD = 2'd3;

  // Packed so that bit 0 is the mode select and bit 3 the odd-parity select.
  typedef struct packed {
    logic odd;
    logic par_en;
    logic two_stop;
    logic sync;
  } ctrl_t;

  typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP} rx_st_e;
endpackage

// File: rtl/sio_baud.sv
module sio_baud #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             tick_q, tick_d;

  always_comb begin
    cnt_d  = cnt_q + DIV_W'(1);
    tick_d = 1'b0;
    if (cnt_q >= div) begin
      cnt_d  = '0;
      tick_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tick_q <= tick_d;
    end
  end

  assign tick = tick_q;
endmodule

// File: rtl/sio_tx.sv
// Transmit shifter for both modes; in synchronous mode it also owns the
// serial clock and captures the incoming bits on each rising edge.
module sio_tx import sio_pkg::*; #(
  parameter int DW = 8,
  parameter int OS = 16   // ticks per bit, power of two
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          start,
  input  logic [DW-1:0] data,
  input  ctrl_t         cfg,
  input  logic          rxd_s,
  output logic          txd,
  output logic          sclk,
  output logic          busy,
  output logic          cap_done,
  output logic [DW-1:0] cap_data
);
  localparam int FW = DW + 4;
  localparam int CW = $clog2(OS);
  localparam int BW = $clog2(FW + 1);
  localparam logic [CW-1:0] T_LAST = CW'(OS - 1);
  localparam logic [CW-1:0] T_PRE  = CW'(OS / 2 - 1);
  localparam logic [CW-1:0] T_RISE = CW'(OS / 2);

  logic          act_q, act_d, sync_q, sync_d, done_q, done_d;
  logic [FW-1:0] frame_q, frame_d;
  logic [BW-1:0] last_q, last_d, bit_q, bit_d;
  logic [CW-1:0] tcnt_q, tcnt_d;
  logic [DW-1:0] cap_q, cap_d;
  logic          pbit;

  assign pbit = (^data) ^ cfg.odd;

  always_comb begin
    act_d   = act_q;
    sync_d  = sync_q;
    frame_d = frame_q;
    last_d  = last_q;
    bit_d   = bit_q;
    tcnt_d  = tcnt_q;
    cap_d   = cap_q;
    done_d  = 1'b0;
    if (!act_q) begin
      if (start) begin
        act_d  = 1'b1;
        sync_d = cfg.sync;
        bit_d  = '0;
        tcnt_d = '0;
        if (cfg.sync) begin
          frame_d = {{(FW - DW){1'b1}}, data};
          last_d  = BW'(DW - 1);
        end else begin
          frame_d = cfg.par_en ? {2'b11, pbit, data, 1'b0} : {3'b111, data, 1'b0};
          last_d  = BW'(DW + 1) + BW'(cfg.par_en) + BW'(cfg.two_stop);
        end
      end
    end else if (tick) begin
      tcnt_d = tcnt_q + CW'(1);
      if (sync_q && tcnt_q == T_PRE) cap_d = {rxd_s, cap_q[DW-1:1]};
      if (tcnt_q == T_LAST) begin
        frame_d = {1'b1, frame_q[FW-1:1]};
        bit_d   = bit_q + BW'(1);
        if (bit_q == last_q) begin
          act_d  = 1'b0;
          done_d = sync_q;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      sync_q  <= 1'b0;
      done_q  <= 1'b0;
      frame_q <= '1;
      last_q  <= '0;
      bit_q   <= '0;
      tcnt_q  <= '0;
      cap_q   <= '0;
    end else begin
      act_q   <= act_d;
      sync_q  <= sync_d;
      done_q  <= done_d;
      frame_q <= frame_d;
      last_q  <= last_d;
      bit_q   <= bit_d;
      tcnt_q  <= tcnt_d;
      cap_q   <= cap_d;
    end
  end

  assign txd      = act_q ? frame_q[0] : 1'b1;
  assign sclk     = ~(act_q & sync_q & (tcnt_q < T_RISE));
  assign busy     = act_q;
  assign cap_done = done_q;
  assign cap_data = cap_q;
endmodule

// File: rtl/sio_rx.sv
// Asynchronous receiver: falling-edge start detect, mid-bit confirmation,
// majority of three tick samples per bit.
module sio_rx import sio_pkg::*; #(
  parameter int DW = 8,
  parameter int OS = 16   // ticks per bit, power of two
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          rxd_s,
  input  logic          par_en,
  input  logic          odd,
  output logic          done,
  output logic [DW-1:0] data,
  output logic          ferr,
  output logic          perr
);
  localparam int CW = $clog2(OS);
  localparam int IW = $clog2(DW);
  localparam logic [CW-1:0] T_CTR = CW'(OS / 2);

  rx_st_e        st_q, st_d;
  logic [CW-1:0] tcnt_q, tcnt_d;
  logic [IW-1:0] bit_q, bit_d;
  logic [DW-1:0] sh_q, sh_d;
  logic [1:0]    smp_q, smp_d;
  logic          pb_q, pb_d, done_q, done_d, ferr_q, ferr_d, perr_q, perr_d;
  logic          maj;

  assign maj = (smp_q[1] & smp_q[0]) | (smp_q[1] & rxd_s) | (smp_q[0] & rxd_s);

  always_comb begin
    st_d   = st_q;
    tcnt_d = tcnt_q;
    bit_d  = bit_q;
    sh_d   = sh_q;
    smp_d  = smp_q;
    pb_d   = pb_q;
    ferr_d = ferr_q;
    perr_d = perr_q;
    done_d = 1'b0;
    if (tick) begin
      smp_d = {smp_q[0], rxd_s};
      if (st_q == RX_IDLE) begin
        if (smp_q[0] && !rxd_s) begin
          st_d   = RX_START;
          tcnt_d = CW'(1);
        end
      end else begin
        tcnt_d = tcnt_q + CW'(1);
        if (tcnt_q == T_CTR) begin
          case (st_q)
            RX_START: begin
              st_d  = maj ? RX_IDLE : RX_DATA;
              bit_d = '0;
            end
            RX_DATA: begin
              sh_d  = {maj, sh_q[DW-1:1]};
              bit_d = bit_q + IW'(1);
              if (bit_q == IW'(DW - 1)) st_d = par_en ? RX_PAR : RX_STOP;
            end
            RX_PAR: begin
              pb_d = maj;
              st_d = RX_STOP;
            end
            default: begin
              done_d = 1'b1;
              ferr_d = ~maj;
              perr_d = par_en & (pb_q ^ (^sh_q) ^ odd);
              st_d   = RX_IDLE;
            end
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RX_IDLE;
      tcnt_q <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      smp_q  <= 2'b11;
      pb_q   <= 1'b0;
      done_q <= 1'b0;
      ferr_q <= 1'b0;
      perr_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      tcnt_q <= tcnt_d;
      bit_q  <= bit_d;
      sh_q   <= sh_d;
      smp_q  <= smp_d;
      pb_q   <= pb_d;
      done_q <= done_d;
      ferr_q <= ferr_d;
      perr_q <= perr_d;
    end
  end

  assign done = done_q;
  assign data = sh_q;
  assign ferr = ferr_q;
  assign perr = perr_q;
endmodule

// File: rtl/sio_top.sv
module sio_top import sio_pkg::*; #(
  parameter int DW    = 8,
  parameter int DIV_W = 8,
  parameter int OS    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          rxd,
  output logic          txd,
  output logic          sclk
);
  logic [1:0]       rst_pipe;
  logic             rst_ni;
  logic [1:0]       rx_pipe;
  logic             rxd_s, tick, tx_busy, start, mode_sync;
  logic             cap_done, rx_done, rx_ferr, rx_perr, new_char, rd_data;
  logic [DW-1:0]    cap_data, rx_data, char_data;
  ctrl_t            ctrl_q, ctrl_d;
  logic [DIV_W-1:0] baud_q, baud_d;
  logic [DW-1:0]    rx_buf, rx_buf_d;
  logic             rx_full, rx_full_d, ferr_q, ferr_d, perr_q, perr_d, ovr_q, ovr_d;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ni = rst_pipe[1];

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) rx_pipe <= 2'b11;
    else         rx_pipe <= {rx_pipe[0], rxd};
  end
  assign rxd_s = rx_pipe[1];

  assign mode_sync = ctrl_q.sync;
  assign start     = bus_wr && bus_addr == A_DATA && !tx_busy;
  assign rd_data   = bus_rd && bus_addr == A_DATA;
  assign new_char  = cap_done | (rx_done & ~mode_sync);
  assign char_data = mode_sync ? cap_data : rx_data;

  sio_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_ni), .div(baud_q), .tick(tick)
  );

  sio_tx #(.DW(DW), .OS(OS)) u_tx (
    .clk(clk), .rst_n(rst_ni), .tick(tick), .start(start), .data(bus_wdata),
    .cfg(ctrl_q), .rxd_s(rxd_s), .txd(txd), .sclk(sclk), .busy(tx_busy),
    .cap_done(cap_done), .cap_data(cap_data)
  );

  sio_rx #(.DW(DW), .OS(OS)) u_rx (
    .clk(clk), .rst_n(rst_ni), .tick(tick & ~mode_sync), .rxd_s(rxd_s),
    .par_en(ctrl_q.par_en), .odd(ctrl_q.odd), .done(rx_done), .data(rx_data),
    .ferr(rx_ferr), .perr(rx_perr)
  );

  always_comb begin
    ctrl_d    = ctrl_q;
    baud_d    = baud_q;
    rx_buf_d  = rx_buf;
    rx_full_d = rx_full;
    ferr_d    = ferr_q;
    perr_d    = perr_q;
    ovr_d     = ovr_q;
    if (bus_wr && bus_addr == A_CTRL) ctrl_d = ctrl_t'(bus_wdata[3:0]);
    if (bus_wr && bus_addr == A_BAUD) baud_d = bus_wdata[DIV_W-1:0];
    if (bus_wr && bus_addr == A_STAT) begin
      ferr_d = 1'b0;
      perr_d = 1'b0;
      ovr_d  = 1'b0;
    end
    if (rd_data) rx_full_d = 1'b0;
    if (new_char) begin
      if (rx_full && !rd_data) begin
        ovr_d = 1'b1;
      end else begin
        rx_buf_d  = char_data;
        rx_full_d = 1'b1;
        ferr_d    = ferr_d | (rx_ferr & ~mode_sync);
        perr_d    = perr_d | (rx_perr & ~mode_sync);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      baud_q  <= '0;
      rx_buf  <= '0;
      rx_full <= 1'b0;
      ferr_q  <= 1'b0;
      perr_q  <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_d;
      baud_q  <= baud_d;
      rx_buf  <= rx_buf_d;
      rx_full <= rx_full_d;
      ferr_q  <= ferr_d;
      perr_q  <= perr_d;
      ovr_q   <= ovr_d;
    end
  end

  always_comb begin
    case (bus_addr)
      A_DATA:  bus_rdata = rx_buf;
      A_CTRL:  bus_rdata = DW'(ctrl_q);
      A_STAT:  bus_rdata = DW'({ovr_q, perr_q, ferr_q, rx_full, tx_busy});
      default: bus_rdata = DW'(baud_q);
    endcase
  end
endmodule

// File: rtl/sio_chk.sv
module sio_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_ni,
  input logic [1:0]    bus_addr,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic          txd,
  input logic          sclk,
  input logic          tx_busy,
  input logic          rx_full,
  input logic [DW-1:0] rx_buf,
  input logic          new_char,
  input logic          mode_sync
);
  // R13: idle asynchronous line levels
  assert_idle_line_R13: assert property (@(posedge clk) disable iff (!rst_ni)
    (!mode_sync && !tx_busy) |-> (txd && sclk))
    else $error("idle line levels wrong");

  // R5: a transmission only begins after a DATA write
  assert_busy_cause_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(tx_busy) |-> $past(bus_wr && bus_addr == 2'd0))
    else $error("transmitter started without a DATA write");

  // R9: a held character is not overwritten
  assert_keep_old_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    (rx_full && $past(rx_full) && !$past(bus_rd && bus_addr == 2'd0)) |-> $stable(rx_buf))
    else $error("held character overwritten");

  // R9: the full flag rises only when a character completes
  assert_fill_cause_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(rx_full) |-> $past(new_char))
    else $error("receive full without a character");

  // R10: reading DATA empties the holding register
  assert_read_clear_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_rd && bus_addr == 2'd0 && !new_char) |=> !rx_full)
    else $error("DATA read did not clear full flag");

  // R11: synchronous data holds while the clock is high
  assert_sync_hold_R11: assert property (@(posedge clk) disable iff (!rst_ni)
    (mode_sync && tx_busy && $past(tx_busy) && sclk && $past(sclk)) |-> $stable(txd))
    else $error("txd changed while sclk high");
endmodule

bind sio_top sio_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_ni(rst_ni), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_rd(bus_rd), .txd(txd), .sclk(sclk), .tx_busy(tx_busy),
  .rx_full(rx_full), .rx_buf(rx_buf), .new_char(new_char), .mode_sync(mode_sync)
);

// File: tb/sio_top_bench.sv
module sio_top_bench;
  logic       clk, rst_n;
  logic [1:0] bus_addr;
  logic       bus_wr, bus_rd;
  logic [7:0] bus_wdata, bus_rdata;
  logic       rxd, txd, sclk;

  int n_chk = 0;
  int n_bad = 0;
  int bitclk = 32;
  int mon_err = 0;
  bit mon_on = 0;

  sio_top #(.DW(8), .DIV_W(8), .OS(16)) u_sio_top (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rxd(rxd), .txd(txd), .sclk(sclk)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Every-clock comparison against the idle-line model while the transmitter is quiet.
  always @(negedge clk) if (mon_on && !(txd === 1'b1 && sclk === 1'b1)) mon_err++;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // Expected line sequence built from the frame rules, sampled at each bit centre.
  task automatic tx_check(input logic [7:0] d, input bit pe, input bit od, input bit two,
                          input int pre, input string tag);
    logic q[$];
    logic [7:0] v;
    q.push_back(1'b0);
    for (int i = 0; i < 8; i++) q.push_back(d[i]);
    if (pe) q.push_back((^d) ^ od);
    q.push_back(1'b1);
    if (two) q.push_back(1'b1);
    repeat (bitclk / 2 - pre) @(negedge clk);
    for (int i = 0; i < q.size(); i++) begin
      chk($sformatf("%s line bit %0d", tag, i), int'(txd), int'(q[i]));
      if (i < q.size() - 1) repeat (bitclk) @(negedge clk);
    end
    rd_reg(2'd2, v);
    chk({tag, " busy during last bit"}, int'(v[0]), 1);
    repeat (bitclk / 2 + 4) @(negedge clk);
    rd_reg(2'd2, v);
    chk({tag, " busy cleared after frame"}, int'(v[0]), 0);
  endtask

  task automatic rx_send(input logic [7:0] d, input bit pe, input bit od, input bit badp,
                         input logic stopv, input bit glitch);
    logic q[$];
    q.push_back(1'b0);
    for (int i = 0; i < 8; i++) q.push_back(d[i]);
    if (pe) q.push_back((^d) ^ od ^ badp);
    q.push_back(stopv);
    for (int i = 0; i < q.size(); i++) begin
      for (int c = 0; c < bitclk; c++) begin
        rxd = (glitch && i == 3 && (c == bitclk / 2 - 3 || c == bitclk / 2 - 2)) ? ~q[i] : q[i];
        @(negedge clk);
      end
    end
    rxd = 1'b1;
    repeat (bitclk) @(negedge clk);
  endtask

  task automatic sync_xfer(input logic [7:0] d, input logic [7:0] s, output logic [7:0] got);
    rxd = s[0];
    wr_reg(2'd0, d);
    for (int i = 0; i < 8; i++) begin
      @(posedge sclk);
      got[i] = txd;
      if (i < 7) begin
        @(negedge sclk);
        rxd = s[i + 1];
      end
    end
    repeat (bitclk) @(negedge clk);
  endtask

  initial begin
    #(200000 * 8);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] v, got;
    rst_n = 1'b0; bus_addr = 2'd0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = 8'h00; rxd = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk("R1 txd", int'(txd), 1);
    chk("R1 sclk", int'(sclk), 1);
    rd_reg(2'd2, v); chk("R1 status", int'(v), 0);
    rd_reg(2'd1, v); chk("R1 ctrl", int'(v), 0);
    rd_reg(2'd3, v); chk("R1 baud", int'(v), 0);

    wr_reg(2'd3, 8'd1); bitclk = 32;
    rd_reg(2'd3, v); chk("R2 baud readback", int'(v), 1);

    // R3: 8N1 and two stop bits
    wr_reg(2'd1, 8'h00); wr_reg(2'd0, 8'hA5); tx_check(8'hA5, 0, 0, 0, 0, "R3 8N1");
    wr_reg(2'd1, 8'h02); wr_reg(2'd0, 8'h5A); tx_check(8'h5A, 0, 0, 1, 0, "R3 two stop");
    // R4: even then odd parity
    wr_reg(2'd1, 8'h04); wr_reg(2'd0, 8'h37); tx_check(8'h37, 1, 0, 0, 0, "R4 even");
    wr_reg(2'd1, 8'h0C); wr_reg(2'd0, 8'h37); tx_check(8'h37, 1, 1, 0, 0, "R4 odd");
    // R5: second write while busy is dropped
    wr_reg(2'd1, 8'h00); wr_reg(2'd0, 8'h55); wr_reg(2'd0, 8'hAA);
    tx_check(8'h55, 0, 0, 0, 2, "R5 busy write ignored");
    // R2: slower divisor stretches every bit
    wr_reg(2'd3, 8'd3); bitclk = 64;
    wr_reg(2'd0, 8'hC3); tx_check(8'hC3, 0, 0, 0, 0, "R2 divisor 3");
    wr_reg(2'd3, 8'd1); bitclk = 32;

    // Receive path, async mode; transmitter idle all along
    mon_on = 1;
    rx_send(8'h6B, 0, 0, 0, 1'b1, 0);
    rd_reg(2'd2, v); chk("R6 status after clean char", int'(v), 8'h02);
    rd_reg(2'd0, v); chk("R6 clean char", int'(v), 8'h6B);
    rd_reg(2'd2, v); chk("R10 full cleared by read", int'(v), 8'h00);

    rx_send(8'h9E, 0, 0, 0, 1'b1, 1);
    rd_reg(2'd0, v); chk("R6 glitch voted out", int'(v), 8'h9E);
    rxd = 1'b0; repeat (4) @(negedge clk); rxd = 1'b1;
    repeat (3 * bitclk) @(negedge clk);
    rd_reg(2'd2, v); chk("R6 false start ignored", int'(v), 8'h00);

    rx_send(8'h11, 0, 0, 0, 1'b0, 0);
    rd_reg(2'd2, v); chk("R7 framing flag", int'(v), 8'h06);
    rd_reg(2'd0, v); chk("R7 data kept", int'(v), 8'h11);
    wr_reg(2'd2, 8'h00);
    rd_reg(2'd2, v); chk("R10 status write clears errors", int'(v), 8'h00);

    wr_reg(2'd1, 8'h04);
    rx_send(8'h3C, 1, 0, 0, 1'b1, 0);
    rd_reg(2'd2, v); chk("R8 good parity", int'(v), 8'h02);
    rd_reg(2'd0, v);
    rx_send(8'h3C, 1, 0, 1, 1'b1, 0);
    rd_reg(2'd2, v); chk("R8 bad parity", int'(v), 8'h0A);
    rd_reg(2'd0, v); wr_reg(2'd2, 8'h00);

    wr_reg(2'd1, 8'h00);
    rx_send(8'h21, 0, 0, 0, 1'b1, 0);
    rx_send(8'h42, 0, 0, 0, 1'b1, 0);
    rd_reg(2'd2, v); chk("R9 overrun flag", int'(v), 8'h12);
    rd_reg(2'd0, v); chk("R9 earlier char kept", int'(v), 8'h21);
    wr_reg(2'd2, 8'h00);
    mon_on = 0;
    chk("R13 idle line every clock", mon_err, 0);

    // Synchronous mode
    wr_reg(2'd1, 8'h01);
    sync_xfer(8'hB4, 8'h6D, got);
    chk("R11 bits on txd", int'(got), 8'hB4);
    chk("R11 sclk idles high", int'(sclk), 1);
    rd_reg(2'd2, v); chk("R11 status after transfer", int'(v), 8'h02);
    rd_reg(2'd0, v); chk("R11 captured byte", int'(v), 8'h6D);

    sync_xfer(8'h01, 8'h80, got);
    sync_xfer(8'h02, 8'h7F, got);
    chk("R11 second byte on txd", int'(got), 8'h02);
    rd_reg(2'd2, v); chk("R12 only overrun set", int'(v), 8'h12);
    rd_reg(2'd0, v); chk("R12 first byte kept", int'(v), 8'h80);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule